// File: doc/BRIEF.md
# Loop-Forwarding Generate Deque

This block sits between the load-history lookup and the prefetch address calculator of a lookahead prefetcher. Each entry describes one speculated basic block: the static branch that opens it, a sequence tag, and a fixed set of load units. Each unit carries a loop-mode bit, a per-iteration delta, a running address and a forwarded flag. New entries go in at the young end. The calculator works through entries from the old end, one at a time, and reports the running address it reached for every unit when it finishes with an entry.

The deque passes running loop addresses between instances of the same static branch so that a loop body can be prefetched ahead without reading registers again. A new entry can pull from the youngest finished instance already held. A finished entry can push its result into the next waiting instance of the same branch. A forwarded unit is flagged, so the calculator uses the forwarded running address instead of the register-plus-offset formula. A pipeline flush trims speculative entries from the young end. A retire trims finished entries from the old end.

Top module: `loop_fwd_deque`

## Requirements
- R1: After synchronous reset the deque is empty: `gen_valid` is 0 and `push_ready` is 1.
- R2: Entries are handed to the calculator oldest first. `gen_*` shows the oldest entry that is not finished, and a `gen_done` pulse marks that entry finished and moves on to the next one.
- R3: The deque holds DEPTH entries (8 by default). While it is full, `push_ready` is 0 and a push is dropped.
- R4: Loop mode is per unit. Unit u occupies bits [u*32 +: 32] of the address and delta buses and bit u of the loop and forwarded masks. A unit is forwarded only if its loop bit is set in both the source and the destination. A unit that is not forwarded shows `gen_fwd` bit 0 and address 0.
- R5: Front pull: a pushed entry looks for a held, finished entry with the same branch. Each eligible unit gets that entry's result plus the new delta, and is flagged forwarded. Addresses wrap modulo 2^32.
- R6: If several finished instances of the branch are held, front pull takes the youngest one.
- R7: Back push: on `gen_done`, the nearest younger unfinished instance of the same branch takes `gen_result` plus its own delta in each eligible unit, and is flagged forwarded.
- R8: If no held instance can take the back push, a push of the same branch in the same cycle takes it instead. For units covered by both, the back-push value overrides the front-pull value.
- R9: A flush removes every entry whose sequence tag is younger than `flush_seq`. Tags are compared modulo 2^6: a is younger than b when (a-b) mod 64 lies in 1..31. The flush is applied before a same-cycle push or `gen_done`. A `gen_done` whose entry is flushed has no effect, and the push is still accepted.
- R10: A retire removes, from the old end, finished entries whose tag is not younger than `retire_seq`. It never removes an unfinished entry. Removed entries free space and can no longer be a front-pull source.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| push_valid | input | 1 | New entry offered |
| push_ready | output | 1 | Deque can accept an entry |
| push_branch | input | 12 | Static branch id of the new entry |
| push_seq | input | 6 | Sequence tag of the new entry |
| push_loop | input | 4 | Per-unit loop-mode mask |
| push_delta | input | 128 | Per-unit loop delta |
| gen_valid | output | 1 | An unfinished entry is presented |
| gen_branch | output | 12 | Branch id of the presented entry |
| gen_seq | output | 6 | Sequence tag of the presented entry |
| gen_loop | output | 4 | Loop-mode mask of the presented entry |
| gen_fwd | output | 4 | Units holding a forwarded running address |
| gen_addr | output | 128 | Forwarded running addresses |
| gen_done | input | 1 | Calculator finished the presented entry |
| gen_result | input | 128 | Final running address of each unit |
| flush_valid | input | 1 | Misprediction flush |
| flush_seq | input | 6 | Tag of the mispredicted block |
| retire_valid | input | 1 | Retire notice |
| retire_seq | input | 6 | Tag of the youngest retired block |

## Verification
The hardest situation to reach is the same-cycle collision. An entry finishes, no held younger instance of its branch exists, and a new instance of that branch arrives while an older finished instance is also held, so front pull and back push both claim the newcomer. The stimulus first builds a finished instance and a forwarded waiting instance of one branch. It then raises `gen_done` and `push_valid` in the same cycle with different results and deltas, so the two paths produce distinct addresses. A similar same-cycle stack of flush, done and push for one branch shows that the flush is applied first.

// File: rtl/gdq_pkg.sv
package gdq_pkg;

    localparam int GDQ_AW    = 32;
    localparam int GDQ_UNITS = 4;
    localparam int GDQ_BRW   = 12;
    localparam int GDQ_SEQW  = 6;

    typedef logic [GDQ_AW-1:0] addr_t;
    typedef addr_t [GDQ_UNITS-1:0] addrs_t;

    typedef struct packed {
        logic  lv;
        logic  fwd;
        addr_t addr;
        addr_t delta;
    } unit_t;

    typedef unit_t [GDQ_UNITS-1:0] units_t;

    typedef struct packed {
        logic [GDQ_BRW-1:0]  br;
        logic [GDQ_SEQW-1:0] seq;
        logic                done;
        units_t              u;
    } entry_t;

    // a is strictly younger than b in the wrapping tag space
    function automatic logic gdq_younger(input logic [GDQ_SEQW-1:0] a,
                                         input logic [GDQ_SEQW-1:0] b);
        logic [GDQ_SEQW-1:0] d;
        d = a - b;
        return (d != '0) && !d[GDQ_SEQW-1];
    endfunction

endpackage

// File: rtl/gdq_pick.sv
module gdq_pick #(
    parameter int N         = 8,
    parameter bit LOW_FIRST = 1'b1
) (
    input  logic [N-1:0]         req,
    output logic                 hit,
    output logic [$clog2(N)-1:0] idx
);
    localparam int IW = $clog2(N);

    generate
        if (LOW_FIRST) begin : g_low
            always_comb begin
                hit = 1'b0;
                idx = '0;
                for (int i = N - 1; i >= 0; i--) begin
                    if (req[i]) begin
                        hit = 1'b1;
                        idx = IW'(i);
                    end
                end
            end
        end else begin : g_high
            always_comb begin
                hit = 1'b0;
                idx = '0;
                for (int i = 0; i < N; i++) begin
                    if (req[i]) begin
                        hit = 1'b1;
                        idx = IW'(i);
                    end
                end
            end
        end
    endgenerate

endmodule

// File: rtl/gdq_fwd.sv
module gdq_fwd
    import gdq_pkg::*;
(
    input  units_t                dst_in,
    input  logic                  en,
    input  logic [GDQ_UNITS-1:0]  src_lv,
    input  addrs_t                base,
    output units_t                dst_out
);
    generate
        for (genvar u = 0; u < GDQ_UNITS; u++) begin : g_unit
            always_comb begin
                dst_out[u] = dst_in[u];
                if (en && src_lv[u] && dst_in[u].lv) begin
                    dst_out[u].addr = base[u] + dst_in[u].delta;
                    dst_out[u].fwd  = 1'b1;
                end
            end
        end
    endgenerate

endmodule

// File: rtl/loop_fwd_deque.sv
module loop_fwd_deque
    import gdq_pkg::*;
#(
    parameter int DEPTH = 8
) (
    input  logic                        clk,
    input  logic                        rst,
    input  logic                        push_valid,
    output logic                        push_ready,
    input  logic [GDQ_BRW-1:0]          push_branch,
    input  logic [GDQ_SEQW-1:0]         push_seq,
    input  logic [GDQ_UNITS-1:0]        push_loop,
    input  logic [GDQ_UNITS*GDQ_AW-1:0] push_delta,
    output logic                        gen_valid,
    output logic [GDQ_BRW-1:0]          gen_branch,
    output logic [GDQ_SEQW-1:0]         gen_seq,
    output logic [GDQ_UNITS-1:0]        gen_loop,
    output logic [GDQ_UNITS-1:0]        gen_fwd,
    output logic [GDQ_UNITS*GDQ_AW-1:0] gen_addr,
    input  logic                        gen_done,
    input  logic [GDQ_UNITS*GDQ_AW-1:0] gen_result,
    input  logic                        flush_valid,
    input  logic [GDQ_SEQW-1:0]         flush_seq,
    input  logic                        retire_valid,
    input  logic [GDQ_SEQW-1:0]         retire_seq
);
    localparam int IW = $clog2(DEPTH);
    localparam int CW = IW + 1;

    // slot 0 is the oldest entry; nd_q counts finished entries at the old end
    entry_t          ent_q [DEPTH];
    entry_t          ent_n [DEPTH];
    entry_t          mod_e [DEPTH];
    logic [CW-1:0]   cnt_q, nd_q, cnt_n, nd_n;
    logic [CW-1:0]   cnt1, nd1, rk;
    logic            run_f, run_r;
    logic            done_ok, push_ok, bp_to_inc;
    logic [IW-1:0]   nd_idx;
    entry_t          src_e, fp_e, inc_e, gen_e;

    logic [DEPTH-1:0] req_b, req_f;
    logic             bp_hit, fp_hit;
    logic [IW-1:0]    bp_idx, fp_idx;

    units_t                inc0_u, inc1_u, bp_dst, bp_u;
    addrs_t                fp_base, res_base;
    logic [GDQ_UNITS-1:0]  fp_lv, src_lv;

    assign push_ready = (cnt_q < CW'(DEPTH));
    assign push_ok    = push_valid && push_ready;

    // ---- flush trims the young end: surviving prefix length ----
    always_comb begin
        run_f = 1'b1;
        cnt1  = '0;
        for (int i = 0; i < DEPTH; i++) begin
            if (run_f && (CW'(i) < cnt_q) &&
                !(flush_valid && gdq_younger(ent_q[i].seq, flush_seq))) begin
                cnt1 = cnt1 + 1'b1;
            end else begin
                run_f = 1'b0;
            end
        end
    end

    assign nd1     = (nd_q < cnt1) ? nd_q : cnt1;
    assign nd_idx  = nd1[IW-1:0];
    assign done_ok = gen_done && (nd1 < cnt1);
    assign src_e   = ent_q[nd_idx];

    // ---- candidate searches ----
    always_comb begin
        for (int j = 0; j < DEPTH; j++) begin
            req_b[j] = done_ok && (CW'(j) > nd1) && (CW'(j) < cnt1) &&
                       (ent_q[j].br == src_e.br);
            req_f[j] = (CW'(j) < cnt1) && ent_q[j].done &&
                       (ent_q[j].br == push_branch);
        end
    end

    // back push: nearest younger waiting instance
    gdq_pick #(.N(DEPTH), .LOW_FIRST(1'b1)) u_pick_back (
        .req (req_b),
        .hit (bp_hit),
        .idx (bp_idx)
    );

    // front pull: youngest finished instance
    gdq_pick #(.N(DEPTH), .LOW_FIRST(1'b0)) u_pick_front (
        .req (req_f),
        .hit (fp_hit),
        .idx (fp_idx)
    );

    // ---- incoming entry and forwarding datapath ----
    assign fp_e     = ent_q[fp_idx];
    assign res_base = addrs_t'(gen_result);

    always_comb begin
        for (int u = 0; u < GDQ_UNITS; u++) begin
            inc0_u[u].lv    = push_loop[u];
            inc0_u[u].fwd   = 1'b0;
            inc0_u[u].addr  = '0;
            inc0_u[u].delta = push_delta[u*GDQ_AW +: GDQ_AW];
            fp_lv[u]        = fp_e.u[u].lv;
            fp_base[u]      = fp_e.u[u].addr;
            src_lv[u]       = src_e.u[u].lv;
        end
    end

    gdq_fwd u_fwd_front (
        .dst_in  (inc0_u),
        .en      (fp_hit),
        .src_lv  (fp_lv),
        .base    (fp_base),
        .dst_out (inc1_u)
    );

    assign bp_to_inc = done_ok && !bp_hit && push_ok && (push_branch == src_e.br);
    assign bp_dst    = bp_hit ? ent_q[bp_idx].u : inc1_u;

    gdq_fwd u_fwd_back (
        .dst_in  (bp_dst),
        .en      (bp_hit || bp_to_inc),
        .src_lv  (src_lv),
        .base    (res_base),
        .dst_out (bp_u)
    );

    always_comb begin
        inc_e.br   = push_branch;
        inc_e.seq  = push_seq;
        inc_e.done = 1'b0;
        inc_e.u    = bp_to_inc ? bp_u : inc1_u;
    end

    // ---- finish and back-push updates on resident entries ----
    always_comb begin
        for (int i = 0; i < DEPTH; i++) mod_e[i] = ent_q[i];
        if (done_ok) begin
            mod_e[nd_idx].done = 1'b1;
            for (int u = 0; u < GDQ_UNITS; u++)
                mod_e[nd_idx].u[u].addr = res_base[u];
        end
        if (bp_hit) mod_e[bp_idx].u = bp_u;
    end

    // ---- retire trims the old end: finished, not younger than tag ----
    always_comb begin
        run_r = 1'b1;
        rk    = '0;
        for (int i = 0; i < DEPTH; i++) begin
            if (run_r && retire_valid && (CW'(i) < cnt1) && ent_q[i].done &&
                !gdq_younger(ent_q[i].seq, retire_seq)) begin
                rk = rk + 1'b1;
            end else begin
                run_r = 1'b0;
            end
        end
    end

    // ---- compaction and append ----
    always_comb begin
        for (int i = 0; i < DEPTH; i++) begin
            if ((i + int'(rk)) < int'(cnt1)) begin
                ent_n[i] = mod_e[IW'(i + int'(rk))];
            end else if (push_ok && (i == int'(cnt1) - int'(rk))) begin
                ent_n[i] = inc_e;
            end else begin
                ent_n[i] = '0;
            end
        end
        cnt_n = cnt1 - rk + CW'(push_ok);
        nd_n  = nd1 + CW'(done_ok) - rk;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt_q <= '0;
            nd_q  <= '0;
            for (int i = 0; i < DEPTH; i++) ent_q[i] <= '0;
        end else begin
            cnt_q <= cnt_n;
            nd_q  <= nd_n;
            for (int i = 0; i < DEPTH; i++) ent_q[i] <= ent_n[i];
        end
    end

    // ---- presentation to the calculator ----
    assign gen_valid  = (nd_q < cnt_q);
    assign gen_e      = ent_q[nd_q[IW-1:0]];
    assign gen_branch = gen_e.br;
    assign gen_seq    = gen_e.seq;

    always_comb begin
        for (int u = 0; u < GDQ_UNITS; u++) begin
            gen_loop[u]                    = gen_e.u[u].lv;
            gen_fwd[u]                     = gen_e.u[u].fwd;
            gen_addr[u*GDQ_AW +: GDQ_AW]   = gen_e.u[u].addr;
        end
    end

    // ---- assertions ----
    AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (rst)
        cnt_q <= CW'(DEPTH)); // R3

    AST_FULL_HOLDS: assert property (@(posedge clk) disable iff (rst)
        (!push_ready && !flush_valid && !retire_valid) |=> cnt_q == $past(cnt_q)); // R3

    AST_FINISHED_BOUND: assert property (@(posedge clk) disable iff (rst)
        nd_q <= cnt_q); // R2

    AST_FWD_NEEDS_LOOP: assert property (@(posedge clk) disable iff (rst)
        gen_valid |-> ((gen_fwd & ~gen_loop) == '0)); // R4

    AST_FLUSH_YOUNGER_GONE: assert property (@(posedge clk) disable iff (rst)
        (flush_valid && !push_valid) |=>
        !(gen_valid && gdq_younger(gen_seq, $past(flush_seq)))); // R9

    AST_RETIRE_KEEPS_PENDING: assert property (@(posedge clk) disable iff (rst)
        (gen_valid && retire_valid && !flush_valid && !gen_done) |=>
        (gen_valid && gen_seq == $past(gen_seq))); // R10

endmodule

// File: tb/loop_fwd_deque_tb.sv
module loop_fwd_deque_tb;
    import gdq_pkg::*;

    logic         clk = 1'b0;
    logic         rst = 1'b1;
    logic         push_valid = 1'b0;
    logic         push_ready;
    logic [11:0]  push_branch = '0;
    logic [5:0]   push_seq = '0;
    logic [3:0]   push_loop = '0;
    logic [127:0] push_delta = '0;
    logic         gen_valid;
    logic [11:0]  gen_branch;
    logic [5:0]   gen_seq;
    logic [3:0]   gen_loop;
    logic [3:0]   gen_fwd;
    logic [127:0] gen_addr;
    logic         gen_done = 1'b0;
    logic [127:0] gen_result = '0;
    logic         flush_valid = 1'b0;
    logic [5:0]   flush_seq = '0;
    logic         retire_valid = 1'b0;
    logic [5:0]   retire_seq = '0;

    int n_checks = 0;
    int n_errors = 0;
    bit finished = 1'b0;

    always #2 clk = ~clk;

    loop_fwd_deque #(.DEPTH(8)) u_dut (
        .clk(clk), .rst(rst),
        .push_valid(push_valid), .push_ready(push_ready),
        .push_branch(push_branch), .push_seq(push_seq),
        .push_loop(push_loop), .push_delta(push_delta),
        .gen_valid(gen_valid), .gen_branch(gen_branch), .gen_seq(gen_seq),
        .gen_loop(gen_loop), .gen_fwd(gen_fwd), .gen_addr(gen_addr),
        .gen_done(gen_done), .gen_result(gen_result),
        .flush_valid(flush_valid), .flush_seq(flush_seq),
        .retire_valid(retire_valid), .retire_seq(retire_seq)
    );

    function automatic logic [127:0] mk4(input logic [31:0] a0, input logic [31:0] a1,
                                         input logic [31:0] a2, input logic [31:0] a3);
        return {a3, a2, a1, a0};
    endfunction

    function automatic logic [31:0] ua(input int u);
        return gen_addr[u*32 +: 32];
    endfunction

    task automatic chk(input string req, input string what,
                       input logic [127:0] act, input logic [127:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_errors++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    task automatic tick();
        @(posedge clk);
        #1;
        push_valid   = 1'b0;
        gen_done     = 1'b0;
        flush_valid  = 1'b0;
        retire_valid = 1'b0;
    endtask

    task automatic do_reset();
        rst = 1'b1;
        tick();
        tick();
        rst = 1'b0;
    endtask

    task automatic set_push(input logic [11:0] br, input logic [5:0] sq,
                            input logic [3:0] lp, input logic [127:0] dl);
        push_valid  = 1'b1;
        push_branch = br;
        push_seq    = sq;
        push_loop   = lp;
        push_delta  = dl;
    endtask

    task automatic push(input logic [11:0] br, input logic [5:0] sq,
                        input logic [3:0] lp, input logic [127:0] dl);
        set_push(br, sq, lp, dl);
        tick();
    endtask

    task automatic finish_one(input logic [127:0] res);
        gen_done   = 1'b1;
        gen_result = res;
        tick();
    endtask

    task automatic t_reset();
        do_reset();
        chk("R1", "gen_valid after reset", 128'(gen_valid), 128'(0));
        chk("R1", "push_ready after reset", 128'(push_ready), 128'(1));
    endtask

    task automatic t_order();
        do_reset();
        push(12'h0A1, 6'd1, 4'b0000, '0);
        push(12'h0A2, 6'd2, 4'b0000, '0);
        chk("R2", "first presented seq", 128'(gen_seq), 128'(1));
        chk("R4", "no-loop entry not forwarded", 128'(gen_fwd), 128'(0));
        chk("R4", "no-loop entry address", gen_addr, 128'(0));
        finish_one('0);
        chk("R2", "second presented seq", 128'(gen_seq), 128'(2));
        chk("R2", "second presented branch", 128'(gen_branch), 128'(12'h0A2));
        finish_one('0);
        chk("R2", "nothing pending", 128'(gen_valid), 128'(0));
    endtask

    task automatic t_full();
        do_reset();
        for (int i = 1; i <= 8; i++) push(12'(12'h100 + i), 6'(i), 4'b0000, '0);
        chk("R3", "ready low when full", 128'(push_ready), 128'(0));
        push(12'h1FF, 6'd9, 4'b0000, '0);
        for (int i = 1; i <= 8; i++) begin
            chk("R3", "drain order", 128'(gen_seq), 128'(i));
            finish_one('0);
        end
        chk("R3", "refused push absent", 128'(gen_valid), 128'(0));
    endtask

    task automatic t_front_pull();
        do_reset();
        push(12'h005, 6'd1, 4'b0111, '0);
        finish_one(mk4(32'h1000, 32'h2000, 32'h3000, 32'h4000));
        push(12'h005, 6'd2, 4'b1011, mk4(32'h10, 32'h20, 32'h30, 32'h40));
        chk("R5", "pulled entry presented", 128'(gen_seq), 128'(2));
        chk("R4", "per-unit forwarded mask", 128'(gen_fwd), 128'(4'b0011));
        chk("R5", "unit0 running address", 128'(ua(0)), 128'(32'h1010));
        chk("R5", "unit1 running address", 128'(ua(1)), 128'(32'h2020));
        chk("R4", "unit2 incoming not loop", 128'(ua(2)), 128'(0));
        chk("R4", "unit3 resident not loop", 128'(ua(3)), 128'(0));
    endtask

    task automatic t_nearest();
        do_reset();
        push(12'h007, 6'd1, 4'b1111, '0);
        finish_one(mk4(100, 100, 100, 100));
        push(12'h007, 6'd2, 4'b1111, mk4(1, 1, 1, 1));
        chk("R5", "first pull value", 128'(ua(0)), 128'(101));
        finish_one(mk4(200, 200, 200, 200));
        push(12'h007, 6'd3, 4'b1111, mk4(1, 1, 1, 1));
        chk("R6", "youngest source chosen", 128'(ua(0)), 128'(201));
        chk("R6", "all units forwarded", 128'(gen_fwd), 128'(4'b1111));
    endtask

    task automatic t_back_push();
        do_reset();
        push(12'h009, 6'd1, 4'b1111, '0);
        push(12'h009, 6'd2, 4'b0101, mk4(10, 10, 10, 10));
        push(12'h009, 6'd3, 4'b1111, mk4(3, 3, 3, 3));
        chk("R7", "no pull from unfinished", 128'(gen_fwd), 128'(0));
        finish_one(mk4(1000, 1001, 1002, 1003));
        chk("R7", "target presented", 128'(gen_seq), 128'(2));
        chk("R7", "target forwarded mask", 128'(gen_fwd), 128'(4'b0101));
        chk("R7", "target unit0", 128'(ua(0)), 128'(1010));
        chk("R7", "target unit2", 128'(ua(2)), 128'(1012));
        chk("R7", "target unit1 untouched", 128'(ua(1)), 128'(0));
        finish_one(mk4(500, 500, 500, 500));
        chk("R7", "chained forwarded mask", 128'(gen_fwd), 128'(4'b0101));
        chk("R7", "chained unit0", 128'(ua(0)), 128'(503));
    endtask

    task automatic t_priority();
        do_reset();
        push(12'h003, 6'd1, 4'b1111, '0);
        finish_one(mk4(50, 50, 50, 50));
        push(12'h003, 6'd2, 4'b1111, mk4(1, 1, 1, 1));
        chk("R5", "setup pull", 128'(ua(0)), 128'(51));
        gen_done   = 1'b1;
        gen_result = mk4(70, 70, 70, 70);
        set_push(12'h003, 6'd3, 4'b1111, mk4(2, 2, 2, 2));
        tick();
        chk("R8", "newcomer presented", 128'(gen_seq), 128'(3));
        chk("R8", "back push wins", 128'(ua(0)), 128'(72));
        chk("R8", "forwarded mask", 128'(gen_fwd), 128'(4'b1111));
    endtask

    task automatic t_flush();
        do_reset();
        push(12'h0B1, 6'd1, 4'b0000, '0);
        push(12'h0B2, 6'd2, 4'b0000, '0);
        push(12'h0B3, 6'd3, 4'b0000, '0);
        flush_valid = 1'b1;
        flush_seq   = 6'd1;
        set_push(12'h044, 6'd2, 4'b0000, '0);
        tick();
        chk("R9", "older entry kept", 128'(gen_seq), 128'(1));
        finish_one('0);
        chk("R9", "new push after flush", 128'(gen_branch), 128'(12'h044));
        finish_one('0);
        chk("R9", "younger entries removed", 128'(gen_valid), 128'(0));

        do_reset();
        push(12'h0C0, 6'd62, 4'b0000, '0);
        push(12'h0C1, 6'd63, 4'b0000, '0);
        push(12'h0C2, 6'd0, 4'b0000, '0);
        flush_valid = 1'b1;
        flush_seq   = 6'd63;
        tick();
        finish_one('0);
        chk("R9", "wrap: tag 63 kept", 128'(gen_seq), 128'(63));
        finish_one('0);
        chk("R9", "wrap: tag 0 removed", 128'(gen_valid), 128'(0));

        do_reset();
        push(12'h030, 6'd1, 4'b1111, '0);
        flush_valid = 1'b1;
        flush_seq   = 6'd0;
        gen_done    = 1'b1;
        gen_result  = mk4(77, 77, 77, 77);
        set_push(12'h030, 6'd1, 4'b1111, mk4(5, 5, 5, 5));
        tick();
        chk("R9", "push survives flush", 128'(gen_valid), 128'(1));
        chk("R9", "flushed finish ignored", 128'(gen_fwd), 128'(0));
    endtask

    task automatic t_retire();
        do_reset();
        push(12'h011, 6'd1, 4'b1111, '0);
        for (int i = 2; i <= 8; i++) push(12'(12'h020 + i), 6'(i), 4'b0000, '0);
        for (int i = 0; i < 3; i++) finish_one(mk4(9, 9, 9, 9));
        chk("R3", "full with finished entries", 128'(push_ready), 128'(0));
        retire_valid = 1'b1;
        retire_seq   = 6'd5;
        tick();
        chk("R10", "space freed", 128'(push_ready), 128'(1));
        chk("R10", "pending entry kept", 128'(gen_seq), 128'(4));
        push(12'h011, 6'd9, 4'b1111, mk4(1, 1, 1, 1));
        for (int i = 0; i < 5; i++) finish_one('0);
        chk("R10", "newcomer reached", 128'(gen_seq), 128'(9));
        chk("R10", "retired entry not a source", 128'(gen_fwd), 128'(0));
    endtask

    initial begin
        #1;
        t_reset();
        t_order();
        t_full();
        t_front_pull();
        t_nearest();
        t_back_push();
        t_priority();
        t_flush();
        t_retire();
        if (!finished) begin
            finished = 1'b1;
            $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
            $finish;
        end
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!finished) begin
            finished = 1'b1;
            n_checks++;
            n_errors++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
            $finish;
        end
    end

endmodule